// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block sequences whole-array transfers between a fast SRAM and its shadow nonvolatile cells. A store copies SRAM into the shadow cells. A recall copies the shadow cells back into SRAM. Five sources can request a transfer:

- an external request made by pulling a shared store/busy pin low;
- a software store pulse;
- a software recall pulse;
- a falling supply, reported as a rise of a power-fail level;
- a rising supply, reported as a rise of a power-good level.

The cell transfer itself is not modelled. A down-counter stands in for it, and its length is set by a parameter for each direction.

A write-tracking flag records whether the SRAM has been written since the last transfer finished. Hardware stores and power-fail stores are skipped when the array is clean. Software stores always run. While any store runs, the block pulls the shared pin low, and that pin then acts as a busy indication. For the whole of any transfer, the block also tristates the data bus and refuses SRAM access. The pin is open-drain. The block reads the resolved pin level on one port and asserts a pull-down on another.

Top module: `nv_xfer_seq`

## Requirements
- R1: After reset the block is idle: `hsb_pull_lo`, `store_active`, `recall_active`, `dq_hiz` and `dirty` are 0, and `access_ok` is 1.
- R2: A hardware store request is recognised only after `hsb_i` has been sampled low on `DEB_CYC` consecutive clock edges while the block is not pulling the pin. A shorter low pulse starts nothing.
- R3: A store lasts exactly `STORE_CYC` cycles, and `hsb_pull_lo` is 1 in every one of them. A recall lasts exactly `RECALL_CYC` cycles and does not pull the pin.
- R4: A hardware store request or a power-fail rise is ignored when `dirty` is 0.
- R5: A software store pulse starts a store whether or not `dirty` is set.
- R6: A 0-to-1 change of `pwr_fail` starts a store when `dirty` is 1 and `auto_inhibit` is 0. With `auto_inhibit` at 1 it starts nothing, but hardware and software stores still work.
- R7: A 0-to-1 change of `pwr_good` starts a recall with no other command.
- R8: `wr_accept` follows `wr_req` only while the block is idle and `hsb_i` is high. Each accepted write sets `dirty`.
- R9: `dirty` returns to 0 when a store or a recall completes.
- R10: During any transfer, `dq_hiz` is 1 and `access_ok` is 0.
- R11: Requests and writes that arrive during a transfer are discarded. They neither extend the transfer nor start another one after it.
- R12: When several requests arrive in the same idle cycle, the order of precedence is: qualifying power-fail store, power-good recall, hardware store, software store, software recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsb_i | input | 1 | Resolved level of the shared store/busy pin |
| hsb_pull_lo | output | 1 | Open-drain pull-down enable for the shared pin |
| sw_store | input | 1 | Software store request pulse |
| sw_recall | input | 1 | Software recall request pulse |
| pwr_fail | input | 1 | Supply below switch threshold (level) |
| pwr_good | input | 1 | Supply above switch threshold (level) |
| auto_inhibit | input | 1 | Strap that disables power-fail stores |
| wr_req | input | 1 | SRAM write attempt |
| wr_accept | output | 1 | SRAM write allowed this cycle |
| access_ok | output | 1 | SRAM access permitted |
| dq_hiz | output | 1 | Data bus tristate enable |
| store_active | output | 1 | Store in progress |
| recall_active | output | 1 | Recall in progress |
| dirty | output | 1 | SRAM written since last transfer |

## Verification
The bench builds the block with `DEB_CYC`=3, `STORE_CYC`=8 and `RECALL_CYC`=5. At these values a whole transfer fits in a few cycles, so every transfer's length can be counted edge by edge. A two-cycle glitch falls just one sample short of the debounce threshold. The default store length, 10 ms of clock cycles, would make each store far too long to repeat across many vectors. The short settings let each request source, the clean-array skips, the inhibit strap, and same-cycle collisions all be reached within a short run.

// File: rtl/nvx_pkg.sv
// Shared types for the nonvolatile transfer sequencer.
// Assumes: only one transfer can be in progress at a time.
package nvx_pkg;
    typedef enum logic [1:0] {
        X_IDLE   = 2'd0,
        X_STORE  = 2'd1,
        X_RECALL = 2'd2
    } xfer_e;
endpackage

// File: rtl/nvx_debounce.sv
// Filters the shared store/busy pin into a single-cycle hardware store request.
// Assumes: the pin is sampled synchronously and DEB_CYC >= 2. Sampling is
// suspended while the block itself pulls the pin low.
module nvx_debounce #(
    parameter int DEB_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_lvl,
    input  logic sample_en,
    output logic hw_req
);
    localparam int DW = $clog2(DEB_CYC + 1);

    logic [DW-1:0] low_cnt;

    // Count consecutive low samples, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !sample_en || pin_lvl) begin
            low_cnt <= '0;
        end else if (low_cnt != DW'(DEB_CYC)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Fire once, on the edge that takes the DEB_CYC-th low sample.
    always_comb begin
        hw_req = sample_en && !pin_lvl && (low_cnt == DW'(DEB_CYC - 1));
    end

    a_r2_req_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        hw_req |-> $past(!pin_lvl));
endmodule

// File: rtl/nvx_timer.sv
// Stand-in for the cell transfer: a down-counter loaded with the length of
// the selected direction. It signals completion in the final active cycle.
// Assumes: start is raised only while no transfer is active.
module nvx_timer #(
    parameter int STORE_CYC  = 8,
    parameter int RECALL_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_store,
    input  logic active,
    output logic done
);
    localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    // Load the remaining-cycle count on start, then count down while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= start_store ? CW'(STORE_CYC - 1) : CW'(RECALL_CYC - 1);
        end else if (active && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // The last cycle of a transfer is the one in which the count is zero.
    always_comb begin
        done = active && (cnt == '0);
    end
endmodule

// File: rtl/nvx_ctrl.sv
// Arbitrates the transfer request sources and holds the current transfer kind.
// Assumes: pwr_fail and pwr_good are synchronous levels. Edges seen while a
// transfer runs are discarded.
module nvx_ctrl
    import nvx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pwr_fail,
    input  logic  pwr_good,
    input  logic  auto_inhibit,
    input  logic  hw_req,
    input  logic  sw_store,
    input  logic  sw_recall,
    input  logic  dirty,
    input  logic  done,
    output xfer_e state,
    output logic  start,
    output logic  start_store
);
    logic pf_q, pg_q;
    logic pf_rise, pg_rise;

    // Remember the previous supply levels so that rises can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= 1'b0;
            pg_q <= 1'b0;
        end else begin
            pf_q <= pwr_fail;
            pg_q <= pwr_good;
        end
    end

    // Pick at most one request per idle cycle, in fixed precedence order.
    always_comb begin
        pf_rise     = pwr_fail && !pf_q;
        pg_rise     = pwr_good && !pg_q;
        start       = 1'b0;
        start_store = 1'b0;
        if (state == X_IDLE) begin
            if (pf_rise && dirty && !auto_inhibit) begin
                start = 1'b1; start_store = 1'b1;
            end else if (pg_rise) begin
                start = 1'b1;
            end else if (hw_req && dirty) begin
                start = 1'b1; start_store = 1'b1;
            end else if (sw_store) begin
                start = 1'b1; start_store = 1'b1;
            end else if (sw_recall) begin
                start = 1'b1;
            end
        end
    end

    // Enter the chosen transfer and return to idle on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= X_IDLE;
        end else if (start) begin
            state <= start_store ? X_STORE : X_RECALL;
        end else if (done) begin
            state <= X_IDLE;
        end
    end

    a_r11_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state != X_IDLE && !done) |=> (state == $past(state)));
    a_r4_clean_hw_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        (state == X_IDLE && !dirty && !pg_rise && !sw_store && !sw_recall)
            |=> (state == X_IDLE));
    a_r12_pf_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == X_IDLE && pf_rise && dirty && !auto_inhibit) |=> (state == X_STORE));
endmodule

// File: rtl/nvx_dirty.sv
// Tracks whether the SRAM holds data not yet matched by the shadow cells.
// Assumes: writes are only accepted while idle, so a write never coincides
// with completion.
module nvx_dirty (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ok,
    input  logic done,
    output logic dirty
);
    // Set on an accepted write; cleared when a transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty <= 1'b0;
        end else if (done) begin
            dirty <= 1'b0;
        end else if (wr_ok) begin
            dirty <= 1'b1;
        end
    end

    a_r8_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> dirty);
    a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !dirty);
endmodule

// File: rtl/nv_xfer_seq.sv
// Top level of the store/recall sequencer. It combines the pin filter, the
// arbiter, the transfer timer and the write tracker, and derives the bus and
// pin controls from the current transfer.
// Assumes: hsb_i is the synchronised, resolved level of the open-drain pin.
module nv_xfer_seq
    import nvx_pkg::*;
#(
    parameter int DEB_CYC    = 3,
    parameter int STORE_CYC  = 2_000_000,
    parameter int RECALL_CYC = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsb_i,
    output logic hsb_pull_lo,
    input  logic sw_store,
    input  logic sw_recall,
    input  logic pwr_fail,
    input  logic pwr_good,
    input  logic auto_inhibit,
    input  logic wr_req,
    output logic wr_accept,
    output logic access_ok,
    output logic dq_hiz,
    output logic store_active,
    output logic recall_active,
    output logic dirty
);
    xfer_e state;
    logic  hw_req, start, start_store, done, active;

    nvx_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk(clk), .rst_n(rst_n), .pin_lvl(hsb_i),
        .sample_en(!hsb_pull_lo), .hw_req(hw_req)
    );

    nvx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .pwr_good(pwr_good),
        .auto_inhibit(auto_inhibit), .hw_req(hw_req), .sw_store(sw_store),
        .sw_recall(sw_recall), .dirty(dirty), .done(done), .state(state),
        .start(start), .start_store(start_store)
    );

    nvx_timer #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .start_store(start_store),
        .active(active), .done(done)
    );

    nvx_dirty u_dirty (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_accept), .done(done), .dirty(dirty)
    );

    // Derive the pin, bus and access controls from the transfer kind.
    always_comb begin
        active        = (state != X_IDLE);
        store_active  = (state == X_STORE);
        recall_active = (state == X_RECALL);
        hsb_pull_lo   = store_active;
        dq_hiz        = active;
        access_ok     = !active;
        wr_accept     = wr_req && !active && hsb_i;
    end

    a_r8_write_needs_high_pin: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> hsb_i);
    a_r3_pull_during_store: assert property (@(posedge clk) disable iff (!rst_n)
        store_active |-> !hsb_i);
endmodule

// File: tb/sim_nv_xfer_seq.sv
module sim_nv_xfer_seq;
    localparam int DEB = 3;
    localparam int SC  = 8;
    localparam int RC  = 5;

    localparam logic [2:0] OP_WR = 3'd1, OP_HW = 3'd2, OP_SWS = 3'd3,
                           OP_SWR = 3'd4, OP_PF = 3'd5;

    typedef struct packed {
        logic [2:0] op;
        logic       inh;
        logic [1:0] kind;   // 0 none, 1 store, 2 recall
        logic       dirt;   // expected dirty after the vector
    } vec_t;

    localparam vec_t VECS [0:11] = '{
        '{OP_WR,  1'b0, 2'd0, 1'b1},
        '{OP_HW,  1'b0, 2'd1, 1'b0},
        '{OP_HW,  1'b0, 2'd0, 1'b0},
        '{OP_PF,  1'b0, 2'd0, 1'b0},
        '{OP_SWS, 1'b0, 2'd1, 1'b0},
        '{OP_WR,  1'b0, 2'd0, 1'b1},
        '{OP_PF,  1'b0, 2'd1, 1'b0},
        '{OP_WR,  1'b0, 2'd0, 1'b1},
        '{OP_SWR, 1'b0, 2'd2, 1'b0},
        '{OP_WR,  1'b0, 2'd0, 1'b1},
        '{OP_PF,  1'b1, 2'd0, 1'b1},
        '{OP_HW,  1'b1, 2'd1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsb_ext = 1'b1;
    logic hsb_pin;
    logic hsb_pull_lo, sw_store = 0, sw_recall = 0, pwr_fail = 0, pwr_good = 0;
    logic auto_inhibit = 0, wr_req = 0;
    logic wr_accept, access_ok, dq_hiz, store_active, recall_active, dirty;
    int   n_chk = 0, n_bad = 0;
    bit   finished = 0;

    always #2.5 clk = ~clk;

    assign hsb_pin = hsb_ext & ~hsb_pull_lo;

    nv_xfer_seq #(.DEB_CYC(DEB), .STORE_CYC(SC), .RECALL_CYC(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .hsb_i(hsb_pin), .hsb_pull_lo(hsb_pull_lo),
        .sw_store(sw_store), .sw_recall(sw_recall), .pwr_fail(pwr_fail),
        .pwr_good(pwr_good), .auto_inhibit(auto_inhibit), .wr_req(wr_req),
        .wr_accept(wr_accept), .access_ok(access_ok), .dq_hiz(dq_hiz),
        .store_active(store_active), .recall_active(recall_active), .dirty(dirty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int kind_now();
        return store_active ? 1 : (recall_active ? 2 : 0);
    endfunction

    // Count the active cycles of a transfer already seen active, checking the
    // bus controls and the pin level in every one of them.
    task automatic measure(input int exp_kind, input int exp_len, input string req);
        int  len = 1;
        bit  ctl_ok = 1;
        for (int i = 0; i < 100; i++) begin
            if (!dq_hiz || access_ok) ctl_ok = 0;
            if ((exp_kind == 1) == hsb_pin) ctl_ok = 0;
            @(negedge clk);
            if (kind_now() == 0) break;
            len++;
        end
        chk(len == exp_len, req, len, exp_len);
        chk(ctl_ok, "R10 bus/pin control during transfer", ctl_ok, 1);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!hsb_pull_lo && !store_active && !recall_active && !dq_hiz && !dirty && access_ok,
            "R1 reset state", kind_now() + 2 * int'(dirty), 0);

        // R7: power-good rise starts a recall without any command
        pwr_good = 1'b1;
        @(negedge clk);
        chk(kind_now() == 2, "R7 power-good recall", kind_now(), 2);
        measure(2, RC, "R7 R3 recall length");

        // Vector table walk
        foreach (VECS[k]) begin
            auto_inhibit = VECS[k].inh;
            case (VECS[k].op)
                OP_WR:  pulse(wr_req);
                OP_SWS: pulse(sw_store);
                OP_SWR: pulse(sw_recall);
                OP_PF:  pulse(pwr_fail);
                default: begin
                    hsb_ext = 1'b0;
                    repeat (DEB) @(negedge clk);
                end
            endcase
            hsb_ext = 1'b1;
            chk(kind_now() == int'(VECS[k].kind), $sformatf("R2 R4 R5 R6 vector %0d kind", k),
                kind_now(), int'(VECS[k].kind));
            if (VECS[k].kind == 2'd1) measure(1, SC, "R3 store length");
            else if (VECS[k].kind == 2'd2) measure(2, RC, "R3 recall length");
            @(negedge clk);
            chk(dirty == VECS[k].dirt, $sformatf("R8 R9 vector %0d dirty", k),
                int'(dirty), int'(VECS[k].dirt));
        end
        auto_inhibit = 1'b0;

        // R2: a low pulse one sample short of the threshold starts nothing
        pulse(wr_req);
        hsb_ext = 1'b0;
        repeat (DEB - 1) @(negedge clk);
        hsb_ext = 1'b1;
        repeat (3) @(negedge clk);
        chk(kind_now() == 0, "R2 short glitch ignored", kind_now(), 0);

        // R8: write refused while the pin is held low externally
        hsb_ext = 1'b0;
        wr_req = 1'b1;
        #1;
        chk(!wr_accept, "R8 write refused while pin low", int'(wr_accept), 0);
        wr_req = 1'b0;
        hsb_ext = 1'b1;
        repeat (2) @(negedge clk);

        // R12: qualifying power-fail wins over a same-cycle software recall
        pwr_fail = 1'b1;
        pulse(sw_recall);
        pwr_fail = 1'b0;
        chk(kind_now() == 1, "R12 power-fail precedence", kind_now(), 1);
        measure(1, SC, "R12 store length");
        chk(!dirty, "R9 dirty cleared", int'(dirty), 0);

        // R11: requests and writes during a transfer are discarded
        pulse(sw_store);
        @(negedge clk);
        wr_req = 1'b1;
        sw_recall = 1'b1;
        #1;
        chk(!wr_accept, "R11 R8 write refused during store", int'(wr_accept), 0);
        @(negedge clk);
        wr_req = 1'b0;
        sw_recall = 1'b0;
        for (int i = 0; i < 100 && kind_now() != 0; i++) @(negedge clk);
        @(negedge clk);
        chk(kind_now() == 0, "R11 no follow-on transfer", kind_now(), 0);
        chk(!dirty, "R11 write during store dropped", int'(dirty), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule